// File: doc/BRIEF.md
# Iterative RC6-Family Block Encryption Core

This core encrypts one 128-bit block at a time with a cipher of the RC6 family. It uses 32-bit words and 20 rounds, and it completes one round in each clock cycle. Before any encryption, an external agent loads the 44 round keys, one word per cycle. The index input steers each word into one of two single-port key stores. One store holds the even-indexed keys and the other holds the odd-indexed keys, so a round can fetch both of its keys in the same cycle.

After the keys are in place, a strobe captures a plaintext block and encryption starts on its own. The core runs these steps in order:
1. one pre-whitening step,
2. twenty rounds,
3. one post-whitening step.

It then presents the ciphertext on a held output register and pulses a completion flag. The output keeps that value until the next encryption finishes.

Top module: `rc6_core`

## Requirements
- R1: A key write with `wrKey` high stores `keyWord` as round key number `keyIdx`. `keyIdx[0]` selects the odd (1) or even (0) store, and `keyIdx[5:1]` is the word address in that store. Keys may be written in any order. A later write to the same index replaces the earlier value.
- R2: The ciphertext on `cipherOut` is the word concatenation {A,B,C,D}, with A in bits 127:96. It is computed from `blockIn` = {A,B,C,D}, also with A in bits 127:96, as follows:
  - pre-whitening: B += S[0] and D += S[1];
  - each round i = 1..20 computes T = rotl(B*(2B+1), 5) and U = rotl(D*(2D+1), 5);
  - it then forms A' = rotl(A^T, U) + S[2i] and C' = rotl(C^U, T) + S[2i+1];
  - it then rotates the words to (B, C', D, A');
  - post-whitening: A += S[42] and C += S[43].
  - All arithmetic is modulo 2^32.
- R3: A data-dependent rotation uses only the low 5 bits of T or U as its amount.
- R4: `done` rises at the 22nd rising clock edge after the edge that captures `wrBlock`. That is one cycle of pre-whitening, 20 round cycles and one cycle of post-whitening. `cipherOut` changes at that same edge.
- R5: `done` is high for exactly one cycle per encryption.
- R6: `cipherOut` holds its value between completions.
- R7: While `rst` is high at a clock edge, the core clears `cipherOut` and `done`, and any encryption in progress is abandoned. After reset, `cipherOut` reads zero until the first completion.
- R8: A `wrBlock` pulse that arrives while an encryption is running is ignored. The running block finishes on its original schedule with its own ciphertext.
- R9: Reset does not clear the key stores. An encryption after reset, without any reload of the keys, uses the keys written before the reset.
- R10: A `wrBlock` in the cycle in which `done` is high is accepted and starts a new encryption.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| blockIn | input | 128 | Plaintext block {A,B,C,D} |
| wrBlock | input | 1 | Captures `blockIn` and starts an encryption when idle |
| keyWord | input | 32 | Round key value to store |
| keyIdx | input | 6 | Round key index |
| wrKey | input | 1 | Key write strobe |
| cipherOut | output | 128 | Held ciphertext {A,B,C,D} |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a second start strobe that lands inside a running encryption. It is hard because nothing outside the core shows that the block is busy except the missing completion pulse. The stimulus counts cycles from its own start strobe and fires a second strobe with a different block a few rounds in. It then checks that the completion still comes at the original cycle and that it carries the first block's ciphertext. A reset fired in the middle of a run, followed by an encryption with no key reload, covers both abandoning a run and keeping the stored keys.

// File: rtl/rc6_pkg.sv
package rc6_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INIT  = 2'd1,
    ST_ROUND = 2'd2,
    ST_FINAL = 2'd3
  } rc6_state_e;

  typedef struct packed {
    logic loadIn;
    logic initStep;
    logic roundStep;
    logic finalStep;
  } rc6_ctrl_t;

endpackage

// File: rtl/rc6_keymem.sv
module rc6_keymem #(
  parameter int WORD  = 32,
  parameter int DEPTH = 22,
  parameter int ADDRW = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [ADDRW-1:0] wrAddr,
  input  logic [WORD-1:0]  wrData,
  input  logic [ADDRW-1:0] rdAddr,
  output logic [WORD-1:0]  rdData
);

  logic [WORD-1:0] mem [DEPTH];

  // single port: a write takes the port, otherwise the round address reads
  logic [ADDRW-1:0] portAddr;
  assign portAddr = wrEn ? wrAddr : rdAddr;

  always_ff @(posedge clk) begin
    if (wrEn && (int'(wrAddr) < DEPTH)) begin
      mem[portAddr] <= wrData;
    end
  end

  assign rdData = (int'(portAddr) < DEPTH) ? mem[portAddr] : '0;

  AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> (int'(rdAddr) < DEPTH)) else $error("read address out of range"); // R1

endmodule

// File: rtl/rc6_ctrl.sv
module rc6_ctrl
  import rc6_pkg::*;
#(
  parameter int ROUNDS = 20,
  parameter int ADDRW  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrBlock,
  output rc6_ctrl_t        ctl,
  output logic [ADDRW-1:0] rdAddr,
  output logic             done
);

  localparam int CNTW = $clog2(ROUNDS + 1);

  rc6_state_e      state;
  logic [CNTW-1:0] roundCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      roundCnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE:  if (wrBlock) state <= ST_INIT;
        ST_INIT: begin
          state    <= ST_ROUND;
          roundCnt <= CNTW'(1);
        end
        ST_ROUND: begin
          if (roundCnt == CNTW'(ROUNDS)) state <= ST_FINAL;
          else roundCnt <= roundCnt + 1'b1;
        end
        ST_FINAL: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadIn    = (state == ST_IDLE) && wrBlock;
    ctl.initStep  = (state == ST_INIT);
    ctl.roundStep = (state == ST_ROUND);
    ctl.finalStep = (state == ST_FINAL);
    unique case (state)
      ST_ROUND: rdAddr = ADDRW'(roundCnt);
      ST_FINAL: rdAddr = ADDRW'(ROUNDS + 1);
      default:  rdAddr = '0;
    endcase
  end

  AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ROUND) |-> (roundCnt >= CNTW'(1) && roundCnt <= CNTW'(ROUNDS)))
    else $error("round counter out of range"); // R4
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && wrBlock) |=> (state == ST_INIT)) else $error("start lost"); // R10
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && wrBlock) |=> (state != ST_INIT)) else $error("restart while busy"); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R5

endmodule

// File: rtl/rc6_datapath.sv
module rc6_datapath
  import rc6_pkg::*;
#(
  parameter int WORD = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  rc6_ctrl_t         ctl,
  input  logic [4*WORD-1:0] blockIn,
  input  logic [WORD-1:0]   kEven,
  input  logic [WORD-1:0]   kOdd,
  output logic [4*WORD-1:0] cipherOut
);

  localparam int LG = $clog2(WORD);

  function automatic logic [WORD-1:0] rotl(input logic [WORD-1:0] x,
                                            input logic [LG-1:0] n);
    logic [2*WORD-1:0] dbl;
    dbl = {x, x} << n;
    return dbl[2*WORD-1:WORD];
  endfunction

  logic [WORD-1:0] wA, wB, wC, wD;
  logic [WORD-1:0] tMix, uMix, aNext, cNext;

  always_comb begin
    tMix  = rotl(wB * ((wB << 1) + 1'b1), LG[LG-1:0]);
    uMix  = rotl(wD * ((wD << 1) + 1'b1), LG[LG-1:0]);
    aNext = rotl(wA ^ tMix, uMix[LG-1:0]) + kEven;
    cNext = rotl(wC ^ uMix, tMix[LG-1:0]) + kOdd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wA <= '0; wB <= '0; wC <= '0; wD <= '0;
      cipherOut <= '0;
    end else begin
      if (ctl.loadIn) begin
        {wA, wB, wC, wD} <= blockIn;
      end
      if (ctl.initStep) begin
        wB <= wB + kEven;
        wD <= wD + kOdd;
      end
      if (ctl.roundStep) begin
        wA <= wB;
        wB <= cNext;
        wC <= wD;
        wD <= aNext;
      end
      if (ctl.finalStep) begin
        cipherOut <= {wA + kEven, wB, wC + kOdd, wD};
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl.finalStep |=> $stable(cipherOut)) else $error("output moved without completion"); // R6
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones({ctl.loadIn, ctl.initStep, ctl.roundStep, ctl.finalStep}) <= 1)
    else $error("overlapping datapath strobes"); // R4

endmodule

// File: rtl/rc6_core.sv
module rc6_core
  import rc6_pkg::*;
#(
  parameter  int WORD   = 32,
  parameter  int ROUNDS = 20,
  localparam int IDXW   = $clog2(2 * ROUNDS + 4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4*WORD-1:0] blockIn,
  input  logic              wrBlock,
  input  logic [WORD-1:0]   keyWord,
  input  logic [IDXW-1:0]   keyIdx,
  input  logic              wrKey,
  output logic [4*WORD-1:0] cipherOut,
  output logic              done
);

  localparam int ADDRW = IDXW - 1;
  localparam int DEPTH = ROUNDS + 2;

  rc6_ctrl_t       ctl;
  logic [ADDRW-1:0] rdAddr;
  logic [WORD-1:0]  kEven, kOdd;
  logic             wrEven, wrOdd;

  assign wrEven = wrKey && !keyIdx[0];
  assign wrOdd  = wrKey &&  keyIdx[0];

  rc6_ctrl #(.ROUNDS(ROUNDS), .ADDRW(ADDRW)) u_ctrl (
    .clk(clk), .rst(rst), .wrBlock(wrBlock),
    .ctl(ctl), .rdAddr(rdAddr), .done(done)
  );

  rc6_keymem #(.WORD(WORD), .DEPTH(DEPTH), .ADDRW(ADDRW)) u_keyEven (
    .clk(clk), .rst(rst), .wrEn(wrEven), .wrAddr(keyIdx[IDXW-1:1]),
    .wrData(keyWord), .rdAddr(rdAddr), .rdData(kEven)
  );

  rc6_keymem #(.WORD(WORD), .DEPTH(DEPTH), .ADDRW(ADDRW)) u_keyOdd (
    .clk(clk), .rst(rst), .wrEn(wrOdd), .wrAddr(keyIdx[IDXW-1:1]),
    .wrData(keyWord), .rdAddr(rdAddr), .rdData(kOdd)
  );

  rc6_datapath #(.WORD(WORD)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .blockIn(blockIn),
    .kEven(kEven), .kOdd(kOdd), .cipherOut(cipherOut)
  );

endmodule

// File: tb/sim_rc6_core.sv
module sim_rc6_core;

  localparam int W      = 32;
  localparam int R      = 20;
  localparam int NK     = 2 * R + 4;
  localparam int LAT    = R + 3;   // negedges after raising wrBlock until done is seen
  localparam int NVEC   = 6;

  localparam logic [127:0] PT_TAB [NVEC] = '{
    128'h0,
    {4{32'hFFFF_FFFF}},
    128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF,
    128'h8000_0000_0000_0001_7FFF_FFFF_FFFF_FFFE,
    128'hDEAD_BEEF_0BAD_F00D_1234_5678_9ABC_DEF0,
    128'h0000_001F_0000_0020_0000_003F_0000_0001
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] blockIn = '0;
  logic         wrBlock = 1'b0;
  logic [31:0]  keyWord = '0;
  logic [5:0]   keyIdx = '0;
  logic         wrKey = 1'b0;
  logic [127:0] cipherOut;
  logic         done;

  logic [31:0] kb [NK];
  int total = 0;
  int fails = 0;
  int cyc = 0;

  rc6_core u0 (
    .clk(clk), .rst(rst), .blockIn(blockIn), .wrBlock(wrBlock),
    .keyWord(keyWord), .keyIdx(keyIdx), .wrKey(wrKey),
    .cipherOut(cipherOut), .done(done)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    int s;
    s = n % 32;
    return (s == 0) ? x : ((x << s) | (x >> (32 - s)));
  endfunction

  function automatic logic [127:0] refEnc(input logic [127:0] pt);
    logic [31:0] a, b, c, d, t, u, na, nc;
    {a, b, c, d} = pt;
    b = b + kb[0];
    d = d + kb[1];
    for (int i = 1; i <= R; i++) begin
      t  = rl(b * (2 * b + 1), 5);
      u  = rl(d * (2 * d + 1), 5);
      na = rl(a ^ t, int'(u & 32'd31)) + kb[2 * i];
      nc = rl(c ^ u, int'(t & 32'd31)) + kb[2 * i + 1];
      a = b; b = nc; c = d; d = na;
    end
    a = a + kb[2 * R + 2];
    c = c + kb[2 * R + 3];
    return {a, b, c, d};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic putKey(input int j, input logic [31:0] v);
    keyIdx = 6'(j); keyWord = v; wrKey = 1'b1;
    kb[j] = v;
    @(negedge clk);
    wrKey = 1'b0;
  endtask

  // starts at a negedge, raises wrBlock, returns negedge count until done
  task automatic runEnc(input logic [127:0] pt, input int midAt,
                        input logic [127:0] midPt, output int lat);
    blockIn = pt; wrBlock = 1'b1;
    lat = -1;
    for (int c = 1; c <= LAT + 10; c++) begin
      @(negedge clk);
      wrBlock = 1'b0;
      if (c == midAt) begin blockIn = midPt; wrBlock = 1'b1; end
      if (done) begin lat = c; break; end
    end
    wrBlock = 1'b0;
  endtask

  initial begin
    int lat;
    logic [127:0] held;
    @(negedge clk); @(negedge clk);
    chk("R7 reset output", cipherOut, '0);
    chk("R7 reset done", {127'd0, done}, '0);
    rst = 1'b0;
    @(negedge clk);

    // R1: odd keys first ascending, then even keys descending
    for (int j = 1; j < NK; j += 2) putKey(j, 32'hB7E1_5163 + 32'(j) * 32'h9E37_79B9);
    for (int j = NK - 2; j >= 0; j -= 2) putKey(j, 32'h5A5A_0F0F ^ (32'(j) * 32'h0101_0301));
    chk("R7 zero before first completion", cipherOut, '0);

    // vector table: R2/R3 ciphertext, R4 latency, R5 pulse, R6 hold
    for (int v = 0; v < NVEC; v++) begin
      runEnc(PT_TAB[v], 0, '0, lat);
      chk("R4 latency", 128'(lat), 128'(LAT));
      chk("R2 R3 ciphertext", cipherOut, refEnc(PT_TAB[v]));
      held = cipherOut;
      @(negedge clk);
      chk("R5 single-cycle done", {127'd0, done}, '0);
      blockIn = ~PT_TAB[v];
      repeat (5) @(negedge clk);
      chk("R6 output held", cipherOut, held);
    end

    // R8: second start strobe mid-run is ignored
    runEnc(PT_TAB[2], 6, PT_TAB[4], lat);
    chk("R8 latency unchanged", 128'(lat), 128'(LAT));
    chk("R8 first block result", cipherOut, refEnc(PT_TAB[2]));
    repeat (LAT + 2) @(negedge clk);
    chk("R8 no extra completion", cipherOut, refEnc(PT_TAB[2]));

    // R10: start in the done cycle is accepted
    runEnc(PT_TAB[3], 0, '0, lat);
    runEnc(PT_TAB[5], 0, '0, lat);
    chk("R10 back-to-back latency", 128'(lat), 128'(LAT));
    chk("R10 back-to-back result", cipherOut, refEnc(PT_TAB[5]));

    // R1: overwrite keys in both stores, including the last address
    putKey(7, 32'h0F1E_2D3C);
    putKey(42, 32'hCAFE_F00D);
    putKey(43, 32'h1357_9BDF);
    runEnc(PT_TAB[4], 0, '0, lat);
    chk("R1 overwritten keys", cipherOut, refEnc(PT_TAB[4]));

    // R7/R9: reset mid-run, then encrypt with no reload
    blockIn = PT_TAB[1]; wrBlock = 1'b1;
    @(negedge clk); wrBlock = 1'b0;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R7 output cleared mid-run", cipherOut, '0);
    repeat (LAT + 2) @(negedge clk);
    chk("R7 abandoned run no done", {127'd0, done}, '0);
    chk("R7 abandoned run output", cipherOut, '0);
    runEnc(PT_TAB[1], 0, '0, lat);
    chk("R9 keys survive reset latency", 128'(lat), 128'(LAT));
    chk("R9 keys survive reset", cipherOut, refEnc(PT_TAB[1]));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule